// File: doc/BRIEF.md
# Shared Pin Source Selector with Masked Readback

This block owns eight shared pins and decides, pin by pin, what drives each one. Three sources can claim a pin. A diagnostic test-point signal has the highest priority. Next comes an external periodic-signal generator. Last is a plain general-purpose output bit. A pin that none of them claims floats as an input. The generators and the interrupt controller sit outside the block. The block receives the generator outputs and hands back the synchronized pin levels for the interrupt logic to use.

Software sets up the pins through a simple register port. Each pin has an 8-bit rate field, and the value of that field decides how the pin is used. Four more registers are eight bits wide with one bit per pin: direction, output data, read mask and test-point enable. A read-only status address returns the synchronized pin levels, with every masked bit forced to zero. The register port has no stream traffic and no back-pressure. A read request always returns its data one cycle later, with a valid strobe.

Top module: `gp_pin_ctrl`

## Requirements
- R1: After reset every register reads as 0, and every pin has its output enable low and its output value 0.
- R2: When a pin's test-point enable bit (address 11) is set, the pin drives its test-point input with its output enable high. This holds whatever the pin's rate field or direction bit contains.
- R3: When a pin's test-point bit is clear and its rate field is non-zero but not 0xFF, the pin drives its generator input with its output enable high.
- R4: When a pin's test-point bit is clear and its rate field is 0xFF (GPIO), the direction bit (address 8) decides the pin. A direction bit of 1 makes the pin drive its data bit (address 9) with its output enable high. A direction bit of 0 leaves the output enable low.
- R5: When a pin's test-point bit is clear and its rate field is 0, the pin is an input. Its output enable is low and its output value is 0, even if its direction bit is 1.
- R6: A read of the status address (12) returns the pin inputs as they were two clock edges before the read was registered. Every bit whose read-mask bit (address 10) is set reads as 0.
- R7: The interrupt-level output equals the pin inputs delayed by two clock edges, and the read mask has no effect on it.
- R8: A read request sets the read-valid output on the next cycle, and the read data follows with it. Rate fields sit at addresses 0 to 7, one per pin. A read and a write to the same address in the same cycle return the value held before the write.
- R9: Writes to addresses 12 to 15 change no register, and reads of addresses 13 to 15 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 4 | Read address |
| rd_valid | output | 1 | Read data valid, one cycle after request |
| rd_data | output | 8 | Read data |
| pin_in | input | 8 | Sampled pad levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| gen_in | input | 8 | Periodic-generator outputs, one per pin |
| tp_in | input | 8 | Diagnostic test-point signals, one per pin |
| irq_lvl | output | 8 | Synchronized pin levels for interrupt logic |

## Verification
Two things can happen in the same cycle: a register write and a read of the same address. The bench provokes this on purpose, including a mask write that lands together with a status read. It expects the read to return the contents held before the write. Pin levels also change while a mask update is in flight, so the second clash is between the synchronizer pipeline and the mask update. The bench judges both against a behavioural model that applies the read before the write on every clock.

// File: rtl/gpm_pkg.sv
package gpm_pkg;
  typedef enum logic [1:0] {
    SRC_INPUT = 2'd0,
    SRC_GPIO  = 2'd1,
    SRC_GEN   = 2'd2,
    SRC_TP    = 2'd3
  } pin_src_e;
endpackage

// File: rtl/gpm_sync.sv
module gpm_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[k] <= '0;
      else     st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];

  assert_first_stage_R7: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (st[0] == $past(d)));
endmodule

// File: rtl/gpm_pin_sel.sv
module gpm_pin_sel
  import gpm_pkg::*;
#(
  parameter int          RATE_W    = 8,
  parameter logic [RATE_W-1:0] GPIO_CODE = '1
) (
  input  logic              tp_en,
  input  logic              tp_sig,
  input  logic [RATE_W-1:0] rate,
  input  logic              dir_out,
  input  logic              data_bit,
  input  logic              gen_sig,
  output logic              pad_o,
  output logic              pad_oe,
  output pin_src_e          src
);
  always_comb begin
    if (tp_en)                   src = SRC_TP;
    else if (rate == '0)         src = SRC_INPUT;
    else if (rate != GPIO_CODE)  src = SRC_GEN;
    else                         src = SRC_GPIO;
  end

  always_comb begin
    pad_o  = 1'b0;
    pad_oe = 1'b0;
    unique case (src)
      SRC_TP:    begin pad_o = tp_sig;  pad_oe = 1'b1; end
      SRC_GEN:   begin pad_o = gen_sig; pad_oe = 1'b1; end
      SRC_GPIO:  begin pad_o = dir_out & data_bit; pad_oe = dir_out; end
      default:   begin pad_o = 1'b0;    pad_oe = 1'b0; end
    endcase
  end
endmodule

// File: rtl/gpm_regs.sv
module gpm_regs #(
  parameter int NPINS  = 8,
  parameter int RATE_W = 8,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    rd_en,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [NPINS-1:0]        level_in,
  output logic                    rd_valid,
  output logic [DATA_W-1:0]       rd_data,
  output logic [NPINS*RATE_W-1:0] rate_flat,
  output logic [NPINS-1:0]        dir_q,
  output logic [NPINS-1:0]        data_q,
  output logic [NPINS-1:0]        mask_q,
  output logic [NPINS-1:0]        tp_q
);
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(NPINS);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(NPINS + 1);
  localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(NPINS + 2);
  localparam logic [ADDR_W-1:0] A_TP   = ADDR_W'(NPINS + 3);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NPINS + 4);

  logic [RATE_W-1:0] rate_q [NPINS];
  logic [DATA_W-1:0] rd_d;

  for (genvar i = 0; i < NPINS; i++) begin : g_rate
    always_ff @(posedge clk) begin
      if (rst)
        rate_q[i] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(i))
        rate_q[i] <= wr_data[RATE_W-1:0];
    end
    assign rate_flat[i*RATE_W +: RATE_W] = rate_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      data_q <= '0;
      mask_q <= '0;
      tp_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_DIR)  dir_q  <= wr_data[NPINS-1:0];
      if (wr_addr == A_DATA) data_q <= wr_data[NPINS-1:0];
      if (wr_addr == A_MASK) mask_q <= wr_data[NPINS-1:0];
      if (wr_addr == A_TP)   tp_q   <= wr_data[NPINS-1:0];
    end
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NPINS; i++)
      if (rd_addr == ADDR_W'(i)) rd_d[RATE_W-1:0] = rate_q[i];
    if (rd_addr == A_DIR)  rd_d[NPINS-1:0] = dir_q;
    if (rd_addr == A_DATA) rd_d[NPINS-1:0] = data_q;
    if (rd_addr == A_MASK) rd_d[NPINS-1:0] = mask_q;
    if (rd_addr == A_TP)   rd_d[NPINS-1:0] = tp_q;
    if (rd_addr == A_STAT) rd_d[NPINS-1:0] = level_in & ~mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_d;
    end
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dir_q == '0 && data_q == '0 && mask_q == '0 && tp_q == '0 && !rd_valid));
  assert_masked_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == A_STAT) |=> ((rd_data[NPINS-1:0] & $past(mask_q)) == '0));
  assert_read_strobe_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid);
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rd_valid);
  assert_ro_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr >= A_STAT) |=> ($stable(dir_q) && $stable(data_q) && $stable(mask_q) && $stable(tp_q)));
endmodule

// File: rtl/gp_pin_ctrl.sv
module gp_pin_ctrl
  import gpm_pkg::*;
#(
  parameter int NPINS       = 8,
  parameter int RATE_W      = 8,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  input  logic [NPINS-1:0]  gen_in,
  input  logic [NPINS-1:0]  tp_in,
  output logic [NPINS-1:0]  irq_lvl
);
  localparam logic [RATE_W-1:0] GPIO_CODE = '1;

  logic [NPINS*RATE_W-1:0] rate_flat;
  logic [NPINS-1:0]        dir_q, data_q, mask_q, tp_q;
  logic [NPINS-1:0]        level_s;
  pin_src_e                src [NPINS];

  gpm_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(level_s)
  );

  gpm_regs #(.NPINS(NPINS), .RATE_W(RATE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .level_in(level_s),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .rate_flat(rate_flat), .dir_q(dir_q), .data_q(data_q),
    .mask_q(mask_q), .tp_q(tp_q)
  );

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    gpm_pin_sel #(.RATE_W(RATE_W), .GPIO_CODE(GPIO_CODE)) u_sel (
      .tp_en(tp_q[i]), .tp_sig(tp_in[i]),
      .rate(rate_flat[i*RATE_W +: RATE_W]),
      .dir_out(dir_q[i]), .data_bit(data_q[i]), .gen_sig(gen_in[i]),
      .pad_o(pin_out[i]), .pad_oe(pin_oe[i]), .src(src[i])
    );

    assert_tp_wins_R2: assert property (@(posedge clk) disable iff (rst)
      tp_q[i] |-> (pin_oe[i] && pin_out[i] == tp_in[i]));
    assert_gen_drive_R3: assert property (@(posedge clk) disable iff (rst)
      (!tp_q[i] && rate_flat[i*RATE_W +: RATE_W] != '0 && rate_flat[i*RATE_W +: RATE_W] != GPIO_CODE)
        |-> (pin_oe[i] && pin_out[i] == gen_in[i]));
    assert_gpio_dir_R4: assert property (@(posedge clk) disable iff (rst)
      (!tp_q[i] && rate_flat[i*RATE_W +: RATE_W] == GPIO_CODE)
        |-> (pin_oe[i] == dir_q[i] && (!dir_q[i] || pin_out[i] == data_q[i])));
    assert_off_input_R5: assert property (@(posedge clk) disable iff (rst)
      (!tp_q[i] && rate_flat[i*RATE_W +: RATE_W] == '0) |-> (!pin_oe[i] && !pin_out[i]));
  end

  assign irq_lvl = level_s;

  assert_single_src_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(tp_q & ~pin_oe) == 0);
endmodule

// File: tb/test_gp_pin_ctrl.sv
module test_gp_pin_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic       rd_valid;
  logic [7:0] rd_data, pin_in = '0, pin_out, pin_oe, gen_in = '0, tp_in = '0, irq_lvl;

  gp_pin_ctrl i_gp_pin_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .gen_in(gen_in),
    .tp_in(tp_in), .irq_lvl(irq_lvl)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit reset_phase = 1'b1;
  bit done = 1'b0;

  // behavioural reference state
  byte unsigned m_rate [8];
  logic [7:0] m_dir, m_data, m_mask, m_tp, m_s1, m_s2, m_rdat;
  logic       m_rv;
  int         m_rtag;

  function automatic logic [7:0] m_read(input int a);
    if (a < 8)   return m_rate[a];
    if (a == 8)  return m_dir;
    if (a == 9)  return m_data;
    if (a == 10) return m_mask;
    if (a == 11) return m_tp;
    if (a == 12) return m_s2 & ~m_mask;
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (m_rate[k]) m_rate[k] = 0;
      m_dir = 0; m_data = 0; m_mask = 0; m_tp = 0;
      m_s1 = 0; m_s2 = 0; m_rv = 0; m_rdat = 0; m_rtag = 0;
    end else begin
      m_rv = rd_en;
      if (rd_en) begin
        m_rdat = m_read(int'(rd_addr));
        m_rtag = (reset_phase) ? 1 : (rd_addr == 12) ? 6 : (rd_addr > 12) ? 9 : 8;
      end
      if (wr_en) begin
        if (wr_addr < 8) m_rate[wr_addr] = wr_data;
        else if (wr_addr == 8)  m_dir  = wr_data;
        else if (wr_addr == 9)  m_data = wr_data;
        else if (wr_addr == 10) m_mask = wr_data;
        else if (wr_addr == 11) m_tp   = wr_data;
      end
      m_s2 = m_s1;
      m_s1 = pin_in;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < 8; i++) begin
        logic eo, ev;
        string tag;
        if (reset_phase)                    begin eo = 0; ev = 0; tag = "R1"; end
        else if (m_tp[i])                   begin eo = 1; ev = tp_in[i]; tag = "R2"; end
        else if (m_rate[i] == 0)            begin eo = 0; ev = 0; tag = "R5"; end
        else if (m_rate[i] != 8'hFF)        begin eo = 1; ev = gen_in[i]; tag = "R3"; end
        else                                begin eo = m_dir[i]; ev = m_dir[i] & m_data[i]; tag = "R4"; end
        check(pin_oe[i] === eo && pin_out[i] === ev, tag, $sformatf("pin %0d oe/out", i),
              {6'b0, pin_oe[i], pin_out[i]}, {6'b0, eo, ev});
      end
      check(irq_lvl === m_s2, "R7", "irq_lvl", irq_lvl, m_s2);
      check(rd_valid === m_rv, "R8", "rd_valid", {7'b0, rd_valid}, {7'b0, m_rv});
      if (m_rv)
        check(rd_data === m_rdat, $sformatf("R%0d", m_rtag), "rd_data", rd_data, m_rdat);
    end
  end

  task automatic cyc(input bit we, input int wa, input int wd, input bit re, input int ra);
    @(posedge clk); #1;
    wr_en = we; wr_addr = 4'(wa); wr_data = 8'(wd);
    rd_en = re; rd_addr = 4'(ra);
  endtask

  task automatic wr(input int a, input int d); cyc(1, a, d, 0, 0); endtask
  task automatic rd(input int a);              cyc(0, 0, 0, 1, a); endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R1: all registers read zero after reset
    for (int a = 0; a < 13; a++) rd(a);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    reset_phase = 1'b0;
    // R9: unused addresses and read-only writes
    for (int a = 12; a < 16; a++) wr(a, 8'hA5);
    for (int a = 8; a < 16; a++) rd(a);
    // configure mix of sources
    wr(0, 8'h00);             // R5 input
    wr(1, 8'hFF); wr(2, 8'hFF); wr(7, 8'hFF); // R4 gpio
    wr(3, 8'h05); wr(5, 8'h40); // R3 generator
    wr(4, 8'h01);
    wr(8, 8'b1000_0011);      // dir: pin0 (off) pin1, pin7 out
    wr(9, 8'b1000_0010);
    wr(11, 8'b0011_0000);     // R2: pin4, pin5 test point
    for (int a = 0; a < 12; a++) rd(a);
    // toggle sources, sample status with different masks
    for (int n = 0; n < 40; n++) begin
      pin_in = 8'($urandom); gen_in = 8'($urandom); tp_in = 8'($urandom);
      if (n % 10 == 0) wr(10, 8'($urandom));
      rd(12);
    end
    // same-cycle write and read to the same address (R8), mask vs status
    cyc(1, 8, 8'h5A, 1, 8);
    cyc(1, 10, 8'hF0, 1, 12);
    cyc(1, 10, 8'h0F, 1, 12);
    cyc(1, 3, 8'hFF, 1, 3);
    rd(3); rd(10);
    // random traffic
    for (int n = 0; n < 400; n++) begin
      int a;
      a = int'($urandom_range(0, 15));
      pin_in = 8'($urandom); gen_in = 8'($urandom); tp_in = 8'($urandom);
      cyc($urandom_range(0, 1), a, (($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom)),
          $urandom_range(0, 1), int'($urandom_range(0, 15)));
    end
    cyc(0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule